// File: doc/BRIEF.md
# Lane-Mask Prefix Compaction Allocator

This unit serves one 32-lane SIMD group that pushes values into a shared on-chip buffer. In a single step it packs any set of active lanes, however sparse, into consecutive buffer slots. Each cycle the group presents an active mask and a data word for every lane. Each active lane is given a slot offset equal to the number of active lanes with a lower index. The unit also reports the total active count.

When a request is accepted, every active lane's word is written at the current head plus that lane's offset. On the same clock edge the head moves forward by the total count. A request that would run past the end of the buffer is refused: nothing is written, the head stays where it was, and an overflow flag is raised. A read port lets the consumer fetch any buffer entry.

Top module: `lane_compact_alloc`

## Requirements
- R1: After reset the head is 0, the overflow flag is 0, and `in_ready` is 1.
- R2: Lane i's offset, on `out_offs[i*5 +: 5]`, is the number of set bits in `in_mask` below bit i, where bit i of `in_mask` is lane i. The offset is produced combinationally from the current mask.
- R3: `out_total` equals the number of set bits in `in_mask`.
- R4: On an accepted request, the word `in_data[i*8 +: 8]` of each active lane i is stored at address head+offset. It can be read on `rd_data` by setting `rd_addr` after that edge. Entries for inactive lanes are not written.
- R5: An accepted request that does not overflow advances the head by `out_total` on the same edge as its writes. The next request uses the new head.
- R6: An accepted request with an all-zero mask writes nothing and leaves the head unchanged.
- R7: If head + `out_total` is greater than the depth (64), the request is refused. After that edge `out_ovf` is 1, the head is unchanged and no entry is written. A request that exactly fills the buffer is accepted.
- R8: `out_ovf` reflects the most recent accepted request. A later request that fits clears it.
- R9: With `in_valid` low, the head and buffer do not change, whatever the mask.
- R10: With alternating lanes active (mask 0x55555555), the even lanes get offsets 0 to 15 and the head advances by 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit accepts a request |
| in_mask | input | 32 | Active lanes, bit i is lane i |
| in_data | input | 256 | Per-lane words, lane i at bits i*8+7 to i*8 |
| out_offs | output | 160 | Per-lane slot offsets, 5 bits each |
| out_total | output | 6 | Active lane count |
| out_head | output | 7 | Current head pointer |
| out_ovf | output | 1 | Last accepted request was refused |
| rd_addr | input | 6 | Buffer read address |
| rd_data | output | 8 | Buffer word at `rd_addr` |

## Verification
A wrong offset for any lane shows at once on `out_offs`. One edge later it also shows as a word at the wrong address on the read port, so every written slot is read back and compared. A head that drifts is visible on `out_head` one cycle after the faulty request, and it shifts every later placement. A wrong overflow decision appears as `out_ovf` or the head changing on the edge right after the request, and the exact-fill and one-past cases sit on either side of that boundary.

// File: rtl/lane_compact_alloc.sv
module lane_compact_alloc #(
  parameter int LANES = 32,
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int OW = $clog2(LANES),
  localparam int CW = $clog2(LANES + 1),
  localparam int HW = $clog2(DEPTH + 1),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [LANES-1:0]    in_mask,
  input  logic [LANES*DW-1:0] in_data,
  output logic [LANES*OW-1:0] out_offs,
  output logic [CW-1:0]       out_total,
  output logic [HW-1:0]       out_head,
  output logic                out_ovf,
  input  logic [AW-1:0]       rd_addr,
  output logic [DW-1:0]       rd_data
);

  logic [HW-1:0] head_q;
  logic          ovf_q;
  logic [OW-1:0] off_a [LANES];
  logic [AW-1:0] waddr [LANES];
  logic [CW-1:0] total;
  logic [HW:0]   reach;
  logic          over, fire;
  logic [DW-1:0] mem [DEPTH];

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      off_a[i] = '0;
      for (int j = 0; j < i; j++) off_a[i] = off_a[i] + OW'(in_mask[j]);
    end
    total = '0;
    for (int j = 0; j < LANES; j++) total = total + CW'(in_mask[j]);
  end

  always_comb
    for (int i = 0; i < LANES; i++) waddr[i] = AW'(head_q + HW'(off_a[i]));

  assign reach    = (HW+1)'(head_q) + (HW+1)'(total);
  assign over     = reach > (HW+1)'(DEPTH);
  assign in_ready = 1'b1;
  assign fire     = in_valid & in_ready;

  for (genvar g = 0; g < LANES; g++) begin : g_off
    assign out_offs[g*OW +: OW] = off_a[g];
  end

  assign out_total = total;
  assign out_head  = head_q;
  assign out_ovf   = ovf_q;
  assign rd_data   = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      ovf_q  <= 1'b0;
    end else if (fire) begin
      ovf_q <= over;
      if (!over) head_q <= head_q + HW'(total);
    end
  end

  always_ff @(posedge clk)
    if (rst_n && fire && !over)
      for (int i = 0; i < LANES; i++)
        if (in_mask[i]) mem[waddr[i]] <= in_data[i*DW +: DW];

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (head_q == '0 && !ovf_q));

  p_top_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(off_a[LANES-1]) + 32'(in_mask[LANES-1])) == 32'(total));

  p_full_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (&in_mask) |-> (32'(total) == LANES));

  p_head_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !over) |=> (head_q == $past(head_q) + HW'($past(total))));

  p_zero_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_mask == '0) |=> $stable(head_q));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(head_q) <= DEPTH);

  p_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && over) |=> (ovf_q && $stable(head_q)));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(head_q));

endmodule

// File: tb/test_lane_compact_alloc.sv
module test_lane_compact_alloc;
  localparam int LANES = 32, DW = 8, DEPTH = 64, OW = 5;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic in_ready, out_ovf;
  logic [LANES-1:0] in_mask = '0;
  logic [LANES*DW-1:0] in_data = '0;
  logic [LANES*OW-1:0] out_offs;
  logic [5:0] out_total;
  logic [6:0] out_head;
  logic [5:0] rd_addr = '0;
  logic [7:0] rd_data;

  int vectors = 0, miscompares = 0;
  int head_m = 0;
  int model [DEPTH];
  bit known [DEPTH];

  always #5 clk = ~clk;

  lane_compact_alloc i_lane_compact_alloc (
    .clk, .rst_n, .in_valid, .in_ready, .in_mask, .in_data,
    .out_offs, .out_total, .out_head, .out_ovf, .rd_addr, .rd_data);

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  task automatic readback(string req);
    for (int a = 0; a < DEPTH; a++) if (known[a]) begin
      rd_addr = 6'(a);
      #1 check(req, int'(rd_data), model[a]);
    end
  endtask

  task automatic push(logic [31:0] m, int tag, bit valid);
    int cnt, below, exp_over;
    @(negedge clk);
    in_valid = valid;
    in_mask  = m;
    for (int i = 0; i < LANES; i++) in_data[i*DW +: DW] = 8'(tag * 40 + i);
    #1;
    cnt = 0;
    for (int i = 0; i < LANES; i++) begin
      below = 0;
      for (int j = 0; j < i; j++) below += int'(m[j]);
      if (m[i]) check("R2 offset", int'(out_offs[i*OW +: OW]), below);
      cnt += int'(m[i]);
    end
    check("R3 total", int'(out_total), cnt);
    exp_over = (head_m + cnt > DEPTH);
    @(posedge clk);
    #1;
    if (valid) begin
      if (!exp_over) begin
        below = 0;
        for (int i = 0; i < LANES; i++) if (m[i]) begin
          model[head_m + below] = (tag * 40 + i) & 8'hFF;
          known[head_m + below] = 1'b1;
          below++;
        end
        head_m += cnt;
      end
      check("R7/R8 overflow flag", int'(out_ovf), exp_over);
    end
    check("R5/R6/R9 head", int'(out_head), head_m);
    in_valid = 1'b0;
    readback("R4 buffer contents");
  endtask

  initial begin
    #1_000_000;
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 head after reset", int'(out_head), 0);
    check("R1 ovf after reset", int'(out_ovf), 0);
    check("R1 ready", int'(in_ready), 1);
    rst_n = 1'b1;
    // R10: alternating lanes
    push(32'h5555_5555, 1, 1'b1);
    check("R10 head after alternating", int'(out_head), 16);
    // R9: mask without valid
    push(32'hFFFF_FFFF, 2, 1'b0);
    // R2/R4: full and sparse patterns
    push(32'hFFFF_FFFF, 3, 1'b1);
    push(32'h8000_0001, 4, 1'b1);
    // R6: empty mask
    push(32'h0000_0000, 5, 1'b1);
    // R7: refused (50 + 16 > 64)
    push(32'h0000_FFFF, 6, 1'b1);
    check("R7 ovf raised", int'(out_ovf), 1);
    // R7/R8: exact fill clears flag
    push(32'h0003_FFF0, 7, 1'b1);
    check("R8 ovf cleared", int'(out_ovf), 0);
    check("R7 exact fill head", int'(out_head), 64);
    // R7: one past full
    push(32'h0000_0400, 8, 1'b1);
    check("R7 full refused", int'(out_ovf), 1);
    finish_run();
  end
endmodule